// File: doc/BRIEF.md
# Memory Cycle Step Sequencer

This block paces one storage cycle of a core-memory style processor. A cycle is eight consecutive steps, numbered 0 to 7. Steps 0 to 3 form the read half, in which the addressed word is fetched. Steps 4 to 7 form the write-back half, in which the word is restored or updated. Two mutually exclusive step rings exist. The processor ring carries ordinary cycles. The cycle-steal ring carries direct memory access cycles while the processor ring stays idle. Both rings drive one shared pair of read-half and write-half levels.

The sequencer runs from one fast system clock, and each step lasts a parameterised number of ticks. When no cycle is wanted, it rests at step 7 of whichever ring ran last, which keeps the write-half level high. From that resting step, a new cycle begins in one of three cases: run mode is on, a start pulse arrives, or a cycle-steal request is pending. A stop request holds the sequencer at rest. When the sequencer leaves step 0 or step 4 of either ring, it emits a storage-select pulse of fixed length.

Top module: `mem_cycle_seq`

## Requirements
- R1: While reset is high, and on the first clock after it is released with no request, the processor ring shows step 7 (t_step = 8'h80), x_step is zero, wr_half is 1, rd_half is 0 and sel_pulse is 0.
- R2: At every cycle, exactly one bit is set across the sixteen indicator bits {x_step, t_step}. Bit n of a ring's vector means step n of that ring.
- R3: Once begun, a cycle visits steps 0,1,...,7 in order without skipping. Each step lasts exactly STEP_TICKS clocks, except that step 7 extends while the sequencer rests.
- R4: rd_half is 1 while step 0, 1, 2 or 3 of either ring is shown, and 0 otherwise. wr_half is always the complement of rd_half.
- R5: sel_pulse goes high on the same clock that the shown step changes from 0 to 1 or from 4 to 5, on either ring. It stays high for exactly SEL_TICKS clocks and is low at all other times.
- R6: At the end of step 7, with no run mode, start pulse or cycle-steal request, the sequencer stays at step 7 of the same ring, and wr_half stays 1.
- R7: While the sequencer is at the end of step 7, a run mode or start pulse with no steal request makes the next clock show processor step 0. A steal request makes the next clock show cycle-steal step 0.
- R8: When a steal request and a start pulse or run mode are present together at the end of step 7, the cycle-steal ring is chosen.
- R9: A stop request at the end of step 7 keeps the sequencer resting, whatever else is requested. Releasing it with run mode still on starts a processor cycle on the next clock.
- R10: With run mode held, step 7 of one cycle is followed directly by step 0 of the next cycle, with no extra rest clock.
- R11: Start pulses, steal requests and stop requests seen during steps 0 to 6 neither shorten nor redirect the cycle in progress. Such a cycle always runs through step 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| run_mode | input | 1 | Level: keep starting cycles back to back |
| start_pulse | input | 1 | Request one processor cycle from the resting step |
| steal_req | input | 1 | Request a cycle-steal cycle; wins over processor cycles |
| stop_req | input | 1 | Level: hold at the resting step |
| t_step | output | 8 | One-hot processor-ring step indicators |
| x_step | output | 8 | One-hot cycle-steal-ring step indicators |
| rd_half | output | 1 | High during steps 0 to 3 of either ring |
| wr_half | output | 1 | High during steps 4 to 7 and at rest |
| sel_pulse | output | 1 | Fixed-length pulse after leaving step 0 or 4 |

## Verification
The bound checker watches, on every clock, the properties that hold step by step. It checks that exactly one step indicator is lit across both rings. It checks that the two half levels are complementary and match the lit step. It checks that a step change only ever moves one position forward, and that a new cycle starts only from step 7. It also checks that a stop request or a pending steal request never lets the sequencer leave step 7 toward the wrong place, and that the select pulse rises only on the exit from step 0 or step 4. Other properties need whole scenarios and appear only in the bench. These are the exact step durations and pulse length, the ring chosen for each combination of requests, back-to-back cycles in run mode, and cycles that carry through a stop or stray requests raised mid-way.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam int STEP_COUNT = 8;
  localparam int STEP_W     = $clog2(STEP_COUNT);
  localparam int HALF_STEP  = STEP_COUNT / 2;

  localparam logic [STEP_W-1:0] FIRST_STEP = '0;
  localparam logic [STEP_W-1:0] MID_STEP   = STEP_W'(HALF_STEP);
  localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(STEP_COUNT - 1);

  typedef enum logic {
    RING_T = 1'b0,
    RING_X = 1'b1
  } ring_e;

  typedef struct packed {
    ring_e               ring;
    logic [STEP_W-1:0]   step;
  } seq_pos_t;

  localparam seq_pos_t PARK_POS = '{ring: RING_T, step: LAST_STEP};

endpackage

// File: rtl/mcs_step_timer.sv
// Counts the ticks of the current step. The counter is left at its
// terminal value while the sequencer rests, so a launch decision can be
// taken on any clock once the resting step has run its course.
module mcs_step_timer #(
  parameter int TICKS = 45
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output logic done
);

  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] TERM = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == TERM);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= TERM;
    end else if (advance) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mcs_ring_ctrl.sv
// Holds the ring and step position and decides where to go next.
// Priority at the end of the last step: stop, then steal, then run/start.
module mcs_ring_ctrl
  import mcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     done,
  input  logic     run_mode,
  input  logic     start_pulse,
  input  logic     steal_req,
  input  logic     stop_req,
  output seq_pos_t pos_d,
  output logic     advance,
  output logic     fire
);

  seq_pos_t pos_q;
  logic     at_last;
  logic     launch_want;
  logic     at_sync_step;

  assign at_last      = (pos_q.step == LAST_STEP);
  assign launch_want  = steal_req | run_mode | start_pulse;
  assign at_sync_step = (pos_q.step == FIRST_STEP) || (pos_q.step == MID_STEP);

  always_comb begin
    advance = done & (!at_last | (!stop_req & launch_want));
    pos_d   = pos_q;
    if (advance) begin
      if (at_last) begin
        pos_d.step = FIRST_STEP;
        pos_d.ring = steal_req ? RING_X : RING_T;
      end else begin
        pos_d.step = pos_q.step + 1'b1;
      end
    end
    fire = advance & at_sync_step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= PARK_POS;
    end else begin
      pos_q <= pos_d;
    end
  end

endmodule

// File: rtl/mcs_sel_pulse.sv
// Retriggerable one-shot: high for WIDTH clocks starting at the fire edge.
module mcs_sel_pulse #(
  parameter int WIDTH = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse_q
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] RELOAD = CW'(WIDTH - 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      pulse_q <= 1'b0;
    end else if (fire) begin
      left_q  <= RELOAD;
      pulse_q <= 1'b1;
    end else begin
      pulse_q <= (left_q != '0);
      if (left_q != '0) begin
        left_q <= left_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/mem_cycle_seq.sv
// Top of the memory cycle step sequencer. All outputs are registered and
// loaded from the next position, so they change on the same edge as the
// internal state.
module mem_cycle_seq
  import mcs_pkg::*;
#(
  parameter int STEP_TICKS = 45,
  parameter int SEL_TICKS  = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run_mode,
  input  logic                  start_pulse,
  input  logic                  steal_req,
  input  logic                  stop_req,
  output logic [STEP_COUNT-1:0] t_step,
  output logic [STEP_COUNT-1:0] x_step,
  output logic                  rd_half,
  output logic                  wr_half,
  output logic                  sel_pulse
);

  seq_pos_t              pos_d;
  logic                  advance;
  logic                  done;
  logic                  fire;
  logic [STEP_COUNT-1:0] t_dec;
  logic [STEP_COUNT-1:0] x_dec;
  logic                  rd_d;

  mcs_step_timer #(.TICKS(STEP_TICKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .done    (done)
  );

  mcs_ring_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .done        (done),
    .run_mode    (run_mode),
    .start_pulse (start_pulse),
    .steal_req   (steal_req),
    .stop_req    (stop_req),
    .pos_d       (pos_d),
    .advance     (advance),
    .fire        (fire)
  );

  mcs_sel_pulse #(.WIDTH(SEL_TICKS)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .pulse_q (sel_pulse)
  );

  for (genvar g = 0; g < STEP_COUNT; g++) begin : g_dec
    assign t_dec[g] = (pos_d.ring == RING_T) && (pos_d.step == STEP_W'(g));
    assign x_dec[g] = (pos_d.ring == RING_X) && (pos_d.step == STEP_W'(g));
  end

  assign rd_d = (pos_d.step < MID_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      t_step                 <= '0;
      t_step[STEP_COUNT-1]   <= 1'b1;
      x_step                 <= '0;
      rd_half                <= 1'b0;
      wr_half                <= 1'b1;
    end else begin
      t_step  <= t_dec;
      x_step  <= x_dec;
      rd_half <= rd_d;
      wr_half <= !rd_d;
    end
  end

endmodule

// File: rtl/mcs_seq_checker.sv
module mcs_seq_checker
  import mcs_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  run_mode,
  input logic                  start_pulse,
  input logic                  steal_req,
  input logic                  stop_req,
  input logic [STEP_COUNT-1:0] t_step,
  input logic [STEP_COUNT-1:0] x_step,
  input logic                  rd_half,
  input logic                  wr_half,
  input logic                  sel_pulse
);

  logic [2*STEP_COUNT-1:0] steps;
  logic [STEP_COUNT-1:0]   either;
  logic [STEP_W-1:0]       idx;
  logic                    at_rest;
  logic                    any_request;

  assign steps       = {x_step, t_step};
  assign either      = t_step | x_step;
  assign at_rest     = either[STEP_COUNT-1];
  assign any_request = run_mode | start_pulse | steal_req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < STEP_COUNT; i++) begin
      if (either[i]) idx = STEP_W'(i);
    end
  end

  assert_one_step_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(steps) == 1);

  assert_half_levels_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_half != wr_half) && (rd_half == (|either[HALF_STEP-1:0])));

  assert_step_order_R3: assert property (@(posedge clk) disable iff (rst)
    (idx != $past(idx)) |-> (idx == $past(idx) + 1'b1));

  assert_launch_from_rest_R11: assert property (@(posedge clk) disable iff (rst)
    ($rose(t_step[0]) || $rose(x_step[0])) |-> $past(at_rest));

  assert_stop_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (at_rest && stop_req) |=> at_rest);

  assert_steal_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (at_rest && steal_req && !stop_req) |=> (at_rest || x_step[0]));

  assert_rest_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (at_rest && !any_request) |=> (at_rest && wr_half));

  assert_sel_origin_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_pulse) |-> ((either[1] || either[HALF_STEP+1]) && !$stable(steps)));

endmodule

bind mem_cycle_seq mcs_seq_checker u_seq_chk (
  .clk         (clk),
  .rst         (rst),
  .run_mode    (run_mode),
  .start_pulse (start_pulse),
  .steal_req   (steal_req),
  .stop_req    (stop_req),
  .t_step      (t_step),
  .x_step      (x_step),
  .rd_half     (rd_half),
  .wr_half     (wr_half),
  .sel_pulse   (sel_pulse)
);

// File: tb/tb_mem_cycle_seq.sv
module tb_mem_cycle_seq;

  localparam int CLK_PERIOD = 10;
  localparam int STEP       = 5;
  localparam int SEL        = 3;
  localparam int CYC        = 8 * STEP;

  // bits: [5] run [4] start [3] steal [2] stop [1] launch expected [0] steal ring
  localparam logic [5:0] VEC [8] = '{
    6'b000000,  // R6 nothing requested
    6'b010010,  // R7 start -> T0
    6'b001011,  // R7 steal -> X0
    6'b011011,  // R8 start+steal -> X0
    6'b101011,  // R8 run+steal -> X0
    6'b100100,  // R9 run+stop -> rest
    6'b011100,  // R9 start+steal+stop -> rest
    6'b100010   // R7 run -> T0
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_mode = 1'b0;
  logic       start_pulse = 1'b0;
  logic       steal_req = 1'b0;
  logic       stop_req = 1'b0;
  logic [7:0] t_step;
  logic [7:0] x_step;
  logic       rd_half;
  logic       wr_half;
  logic       sel_pulse;

  int  n_cmp = 0;
  int  n_bad = 0;
  logic last_x = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_cycle_seq #(.STEP_TICKS(STEP), .SEL_TICKS(SEL)) dut (
    .clk         (clk),
    .rst         (rst),
    .run_mode    (run_mode),
    .start_pulse (start_pulse),
    .steal_req   (steal_req),
    .stop_req    (stop_req),
    .t_step      (t_step),
    .x_step      (x_step),
    .rd_half     (rd_half),
    .wr_half     (wr_half),
    .sel_pulse   (sel_pulse)
  );

  task automatic chk(input string req, input logic [7:0] et, input logic [7:0] ex,
                     input logic erd, input logic ewr, input logic esel);
    n_cmp++;
    if ({t_step, x_step, rd_half, wr_half, sel_pulse} !== {et, ex, erd, ewr, esel}) begin
      n_bad++;
      $display("FAIL %s: actual t=%h x=%h rd=%b wr=%b sel=%b expected t=%h x=%h rd=%b wr=%b sel=%b",
               req, t_step, x_step, rd_half, wr_half, sel_pulse, et, ex, erd, ewr, esel);
    end
  endtask

  task automatic chk_rest(input string req, input logic xr);
    chk(req, xr ? 8'h00 : 8'h80, xr ? 8'h80 : 8'h00, 1'b0, 1'b1, 1'b0);
  endtask

  // Entered at the negedge that is clock n0 after the launch edge.
  // inj_mode 1: one-clock start+steal pulse; 2: raise and hold stop.
  task automatic run_cycle(input logic xr, input int n0, input int inj_n, input int inj_mode,
                           input logic [7:0] ft, input logic [7:0] fx, input string req);
    int s;
    int k;
    logic [7:0] oh;
    for (int n = n0; n <= CYC; n++) begin
      s  = (n - 1) / STEP;
      k  = (n - 1) % STEP;
      oh = 8'd1 << s;
      chk(req, xr ? 8'h00 : oh, xr ? oh : 8'h00, s < 4, s >= 4,
          (s == 1 || s == 5) && (k < SEL));
      if (n == inj_n && inj_mode == 1) begin
        start_pulse = 1'b1;
        steal_req   = 1'b1;
      end
      if (n == inj_n && inj_mode == 2) stop_req = 1'b1;
      @(negedge clk);
      if (n == inj_n && inj_mode == 1) begin
        start_pulse = 1'b0;
        steal_req   = 1'b0;
      end
    end
    chk(req, ft, fx, ft[0] | fx[0], !(ft[0] | fx[0]), 1'b0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual run still going expected finished");
    summary();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 during reset", 8'h80, 8'h00, 1'b0, 1'b1, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", 8'h80, 8'h00, 1'b0, 1'b1, 1'b0);

    // Vector table: request combinations presented at rest
    for (int i = 0; i < 8; i++) begin
      {run_mode, start_pulse, steal_req, stop_req} = VEC[i][5:2];
      @(negedge clk);
      run_mode = 1'b0; start_pulse = 1'b0; steal_req = 1'b0; stop_req = 1'b0;
      if (VEC[i][1]) begin
        run_cycle(VEC[i][0], 1, 0, 0, VEC[i][0] ? 8'h00 : 8'h80,
                  VEC[i][0] ? 8'h80 : 8'h00, "R3/R4/R5/R7/R8 vector cycle");
        last_x = VEC[i][0];
      end else begin
        chk_rest("R6/R9 vector rest", last_x);
      end
      @(negedge clk);
      chk_rest("R6 still resting", last_x);
    end

    // R10 back-to-back in run mode
    run_mode = 1'b1;
    @(negedge clk);
    run_cycle(1'b0, 1, 0, 0, 8'h01, 8'h00, "R10 first cycle");
    run_mode = 1'b0;
    @(negedge clk);
    run_cycle(1'b0, 2, 0, 0, 8'h80, 8'h00, "R10 second cycle");

    // R11 stray requests mid-cycle are ignored
    start_pulse = 1'b1;
    @(negedge clk);
    start_pulse = 1'b0;
    run_cycle(1'b0, 1, 2 * STEP + 1, 1, 8'h80, 8'h00, "R11 mid-cycle requests");

    // R9 stop raised mid-cycle with run on: cycle completes, then rests
    run_mode = 1'b1;
    @(negedge clk);
    run_cycle(1'b0, 1, 3 * STEP + 1, 2, 8'h80, 8'h00, "R9/R11 stop mid-cycle");
    @(negedge clk);
    chk_rest("R9 stop holds rest", 1'b0);
    stop_req = 1'b0;
    @(negedge clk);
    run_mode = 1'b0;
    run_cycle(1'b0, 1, 0, 0, 8'h80, 8'h00, "R9 resume after stop");

    // R8 steal under run mode, then back to processor ring
    run_mode  = 1'b1;
    steal_req = 1'b1;
    @(negedge clk);
    steal_req = 1'b0;
    run_cycle(1'b1, 1, 0, 0, 8'h01, 8'h00, "R8 steal then T");
    run_mode = 1'b0;
    @(negedge clk);
    run_cycle(1'b0, 2, 0, 0, 8'h80, 8'h00, "R8 following T cycle");

    summary();
  end

endmodule